// File: doc/BRIEF.md
# Layer Combo and Tile Scheduler

This block is the top-level sequencer of a serial convolutional network accelerator. The network is flattened before run time into an ordered list of layer combos. Each combo has one key layer (convolution, pooling or fully connected) and any number of affiliated layers that consume the key layer's output directly. A producer combo always sits earlier in the list than the combos that use its results, so running the list strictly in order is enough.

Software fills a small configuration register file, one entry per combo, while the block is idle. Each entry holds:

- the key layer kind and the affiliated-layer enables;
- the kernel size, feature map size and unroll factor;
- the tile count and an iteration count.

A start pulse begins the run at combo 0. For each combo in turn, the scheduler copies that combo's entry into a local parameter register, which drives the tile datapath. It then issues one tile at a time. Each tile is a one-cycle `tile_start_o` pulse, and the scheduler waits for the datapath's `tile_done_i` before it issues the next. After the last tile of the last combo it raises `done_o` for one cycle and goes idle.

All pins are plain control and status signals. There is no streaming interface and no back-pressure.

Top module: `combo_tile_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `tile_start_o` are low and `combo_idx_o` is 0.
- R2: While idle, `cfg_we_i` writes `cfg_wdata_i` into entry `cfg_addr_i`. The entry's bit fields are: key kind [1:0] (0 convolution, 1 pooling, 2 fully connected), affiliated enables [5:2], kernel size [9:6], feature map size [17:10], unroll [21:18], tile count [29:22] and iteration count [37:30].
- R3: A write whose key kind field is 3 is dropped, and the entry keeps its previous contents.
- R4: A configuration write presented while busy is dropped.
- R5: A start pulse while idle samples `combo_last_i` and runs combos 0 through that index in ascending order. The first `tile_start_o` appears two cycles after the start cycle. While busy, `start_i` and `combo_last_i` have no effect.
- R6: Before a combo's first tile, `act_cfg_o` carries that combo's entry exactly as stored. It holds that value for every tile of the combo.
- R7: A combo issues as many tiles as its tile count, with `tile_idx_o` counting 0, 1, 2 and so on. A tile count of 0 runs exactly one tile.
- R8: `tile_start_o` is a one-cycle pulse. No further pulse is issued until `tile_done_i` has answered the previous one. `tile_done_i` is ignored at any other time, including while idle.
- R9: `done_o` is a one-cycle pulse in the cycle after the `tile_done_i` of the last tile of the last combo. In the following cycle `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run at combo 0 (honoured only while idle) |
| combo_last_i | input | 4 | Index of the final combo of the run, sampled at start |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 4 | Configuration entry to write |
| cfg_wdata_i | input | 38 | Configuration entry contents |
| tile_done_i | input | 1 | Datapath has finished the outstanding tile |
| tile_start_o | output | 1 | One-cycle pulse launching a tile |
| combo_idx_o | output | 4 | Index of the combo being executed |
| tile_idx_o | output | 8 | Index of the current tile within the combo |
| act_cfg_o | output | 38 | Local copy of the active combo's parameters |
| busy_o | output | 1 | High from the cycle after start until done |
| done_o | output | 1 | One-cycle pulse at the end of the run |

## Verification
The assertions assume that the tile datapath answers each `tile_start_o` with exactly one `tile_done_i`. For example, the check that a new tile follows a completed one reads `tile_done_i` only in the waiting state. They also assume that reset is applied before the first run. The bench's responder keeps to these assumptions: it answers every tile start with a single done pulse after a fixed per-scenario latency, and it sends stray done pulses only while the block is idle, where they must be ignored. Disturbing inputs (a repeated start with a different last index, and a configuration write) are driven during the first tile of a run, when the block is known to be busy.

// File: rtl/cts_pkg.sv
package cts_pkg;

  localparam int KEY_W  = 2;
  localparam int AFF_W  = 4;
  localparam int KERN_W = 4;
  localparam int FMAP_W = 8;
  localparam int UNR_W  = 4;
  localparam int TILE_W = 8;
  localparam int ITER_W = 8;

  typedef enum logic [KEY_W-1:0] {
    KEY_CONV = 2'd0,
    KEY_POOL = 2'd1,
    KEY_FC   = 2'd2,
    KEY_RSVD = 2'd3
  } key_e;

  // Packed so that the key kind sits in the low bits.
  typedef struct packed {
    logic [ITER_W-1:0] iters;
    logic [TILE_W-1:0] tiles;
    logic [UNR_W-1:0]  unroll;
    logic [FMAP_W-1:0] fmap;
    logic [KERN_W-1:0] kern;
    logic [AFF_W-1:0]  affil;
    key_e              key;
  } combo_cfg_t;

  localparam int CFG_W = $bits(combo_cfg_t);

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_ISSUE,
    S_WAIT,
    S_FINISH
  } seq_state_e;

endpackage

// File: rtl/cts_cfg_regs.sv
module cts_cfg_regs
  import cts_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  combo_cfg_t       wr_data_i,
  input  logic [IDX_W-1:0] rd_addr_i,
  output combo_cfg_t       rd_data_o
);

  combo_cfg_t [DEPTH-1:0] store_q;
  logic                   wr_ok;

  assign wr_ok = idle_i && wr_en_i && (wr_data_i.key != KEY_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_ok && (wr_addr_i == IDX_W'(i))) begin
          store_q[i] <= wr_data_i;
        end
      end
    end
  end

  assign rd_data_o = store_q[rd_addr_i];

  // R4
  cfg_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |=> $stable(store_q));

  // R3
  cfg_rsvd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i.key == KEY_RSVD) |=> $stable(store_q));

endmodule

// File: rtl/cts_combo_tracker.sv
module cts_combo_tracker
  import cts_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             begin_i,
  input  logic [IDX_W-1:0] last_i,
  input  logic             load_i,
  input  logic             advance_i,
  input  combo_cfg_t       cfg_i,
  output logic [IDX_W-1:0] combo_idx_o,
  output logic             is_last_o,
  output combo_cfg_t       act_o
);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;
  combo_cfg_t       act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      last_q <= '0;
    end else if (begin_i) begin
      idx_q  <= '0;
      last_q <= last_i;
    end else if (advance_i) begin
      idx_q  <= idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (load_i) begin
      act_q <= cfg_i;
    end
  end

  assign combo_idx_o = idx_q;
  assign is_last_o   = (idx_q == last_q);
  assign act_o       = act_q;

  // R5
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i |-> !is_last_o);

  // R6
  act_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(act_q));

endmodule

// File: rtl/cts_tile_stepper.sv
module cts_tile_stepper
  import cts_pkg::*;
#(
  parameter int CNT_W = TILE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] tiles_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] tile_idx_o,
  output logic             last_tile_o
);

  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] total_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      total_q <= CNT_W'(1);
    end else if (load_i) begin
      idx_q   <= '0;
      total_q <= (tiles_i == '0) ? CNT_W'(1) : tiles_i;
    end else if (step_i) begin
      idx_q   <= idx_q + CNT_W'(1);
    end
  end

  assign tile_idx_o  = idx_q;
  assign last_tile_o = (idx_q == total_q - CNT_W'(1));

  // R7
  tile_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> !last_tile_o);

  // R7
  tile_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    total_q != '0);

endmodule

// File: rtl/combo_tile_seq.sv
module combo_tile_seq
  import cts_pkg::*;
#(
  parameter int MAX_COMBOS = 16,
  localparam int IDX_W = (MAX_COMBOS > 1) ? $clog2(MAX_COMBOS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  combo_last_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              tile_done_i,
  output logic              tile_start_o,
  output logic [IDX_W-1:0]  combo_idx_o,
  output logic [TILE_W-1:0] tile_idx_o,
  output logic [CFG_W-1:0]  act_cfg_o,
  output logic              busy_o,
  output logic              done_o
);

  seq_state_e state_q, state_d;

  logic       idle;
  logic       accept;
  logic       do_load;
  logic       got_done;
  logic       step;
  logic       advance;
  logic       last_tile;
  logic       combo_is_last;
  combo_cfg_t cfg_rd;
  combo_cfg_t act;

  assign idle     = (state_q == S_IDLE);
  assign accept   = idle && start_i;
  assign do_load  = (state_q == S_LOAD);
  assign got_done = (state_q == S_WAIT) && tile_done_i;
  assign step     = got_done && !last_tile;
  assign advance  = got_done && last_tile && !combo_is_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start_i) state_d = S_LOAD;
      S_LOAD:   state_d = S_ISSUE;
      S_ISSUE:  state_d = S_WAIT;
      S_WAIT: begin
        if (tile_done_i) begin
          if (!last_tile)         state_d = S_ISSUE;
          else if (combo_is_last) state_d = S_FINISH;
          else                    state_d = S_LOAD;
        end
      end
      S_FINISH: state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  cts_cfg_regs #(.DEPTH(MAX_COMBOS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_i    (idle),
    .wr_en_i   (cfg_we_i),
    .wr_addr_i (cfg_addr_i),
    .wr_data_i (combo_cfg_t'(cfg_wdata_i)),
    .rd_addr_i (combo_idx_o),
    .rd_data_o (cfg_rd)
  );

  cts_combo_tracker #(.DEPTH(MAX_COMBOS)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .begin_i     (accept),
    .last_i      (combo_last_i),
    .load_i      (do_load),
    .advance_i   (advance),
    .cfg_i       (cfg_rd),
    .combo_idx_o (combo_idx_o),
    .is_last_o   (combo_is_last),
    .act_o       (act)
  );

  cts_tile_stepper #(.CNT_W(TILE_W)) u_tiles (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (do_load),
    .tiles_i     (cfg_rd.tiles),
    .step_i      (step),
    .tile_idx_o  (tile_idx_o),
    .last_tile_o (last_tile)
  );

  assign tile_start_o = (state_q == S_ISSUE);
  assign done_o       = (state_q == S_FINISH);
  assign busy_o       = !idle;
  assign act_cfg_o    = act;

  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tile_start_o |=> !tile_start_o);

  // R8
  tile_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tile_start_o && $past(state_q) == S_WAIT) |-> $past(tile_done_i));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R9
  done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (combo_is_last && $past(tile_done_i)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!tile_start_o && !done_o && !busy_o));

endmodule

// File: tb/sim_combo_tile_seq.sv
module sim_combo_tile_seq;
  import cts_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic [3:0]        combo_last_i;
  logic              cfg_we_i;
  logic [3:0]        cfg_addr_i;
  logic [CFG_W-1:0]  cfg_wdata_i;
  logic              tile_done_i;
  logic              tile_start_o;
  logic [3:0]        combo_idx_o;
  logic [TILE_W-1:0] tile_idx_o;
  logic [CFG_W-1:0]  act_cfg_o;
  logic              busy_o;
  logic              done_o;

  always #2 clk = ~clk;

  combo_tile_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .combo_last_i(combo_last_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .tile_done_i(tile_done_i), .tile_start_o(tile_start_o),
    .combo_idx_o(combo_idx_o), .tile_idx_o(tile_idx_o), .act_cfg_o(act_cfg_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  typedef struct packed {
    logic [4:0] ncombo;
    logic [3:0] base;
    logic [3:0] lat;
    logic [7:0] exp_tiles;
  } vec_t;

  // Tile count of combo k is (base + k) % 4; expected totals clamp 0 to 1.
  localparam vec_t VEC [4] = '{
    '{5'd1,  4'd3, 4'd0, 8'd3},
    '{5'd4,  4'd0, 4'd2, 8'd7},
    '{5'd16, 4'd1, 4'd1, 8'd28},
    '{5'd3,  4'd2, 4'd3, 8'd6}
  };

  int n_chk = 0;
  int n_err = 0;
  logic [CFG_W-1:0] exp_cfg [16];
  int exp_tc [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [CFG_W-1:0] mk_cfg(input int k, input int tiles, input int salt);
    combo_cfg_t c;
    c.key    = key_e'(2'((k + salt) % 3));
    c.affil  = 4'(k + salt);
    c.kern   = 4'(1 + 2 * (k % 3));
    c.fmap   = 8'(7 * k + salt + 3);
    c.unroll = 4'(k % 4 + 1);
    c.tiles  = 8'(tiles);
    c.iters  = 8'(5 * k + salt);
    return c;
  endfunction

  task automatic wr(input int addr, input logic [CFG_W-1:0] data);
    cfg_we_i    = 1'b1;
    cfg_addr_i  = 4'(addr);
    cfg_wdata_i = data;
    tick();
    cfg_we_i    = 1'b0;
  endtask

  task automatic prog(input int n, input int base, input int salt);
    for (int k = 0; k < n; k++) begin
      exp_tc[k]  = (base + k) % 4;
      exp_cfg[k] = mk_cfg(k, exp_tc[k], salt);
      wr(k, exp_cfg[k]);
    end
  endtask

  task automatic run(input int n, input int lat, input int exp_tiles, input bit disturb);
    int ec = 0;
    int et = 0;
    int seen = 0;
    int cnt = -1;
    bit outst = 0;
    bit last_td = 0;
    bit first = 1;
    bit fin = 0;
    start_i      = 1'b1;
    combo_last_i = 4'(n - 1);
    tick();
    start_i = 1'b0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      last_td     = tile_done_i;
      tile_done_i = 1'b0;
      start_i     = 1'b0;
      cfg_we_i    = 1'b0;
      if (done_o) begin
        chk(last_td == 1'b1, "R9", "done follows final tile_done", 64'(last_td), 64'd1);
        chk(seen == exp_tiles, "R7", "tile count of run", 64'(seen), 64'(exp_tiles));
        chk(ec == n, "R5", "combos completed", 64'(ec), 64'(n));
        fin = 1;
        break;
      end
      if (tile_start_o) begin
        if (first) begin
          chk(cyc == 1, "R5", "first tile latency", 64'(cyc), 64'd1);
          first = 0;
          if (disturb) begin
            start_i      = 1'b1;
            combo_last_i = 4'd0;
            cfg_we_i     = 1'b1;
            cfg_addr_i   = 4'(n - 1);
            cfg_wdata_i  = mk_cfg(9, 1, 7);
          end
        end
        chk(!outst, "R8", "tile issued before done", 64'(outst), 64'd0);
        chk(combo_idx_o == 4'(ec), "R5", "combo index", 64'(combo_idx_o), 64'(ec));
        chk(tile_idx_o == 8'(et), "R7", "tile index", 64'(tile_idx_o), 64'(et));
        chk(act_cfg_o == exp_cfg[ec], "R6", "active parameters", 64'(act_cfg_o), 64'(exp_cfg[ec]));
        seen++;
        outst = 1;
        cnt = lat;
        et++;
        if (et >= ((exp_tc[ec] == 0) ? 1 : exp_tc[ec])) begin
          et = 0;
          ec++;
        end
      end else if (cnt == 0) begin
        tile_done_i = 1'b1;
        outst = 0;
        cnt = -1;
      end else if (cnt > 0) begin
        cnt--;
      end
      tick();
    end
    chk(fin, "R9", "run finished", 64'(fin), 64'd1);
    tick();
    chk(!done_o && !busy_o, "R9", "one-cycle done then idle",
        64'({done_o, busy_o}), 64'd0);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    combo_last_i = '0;
    cfg_we_i = 1'b0;
    cfg_addr_i = '0;
    cfg_wdata_i = '0;
    tile_done_i = 1'b0;
    tick();
    tick();
    // R1
    chk(!busy_o && !done_o && !tile_start_o && combo_idx_o == 4'd0, "R1", "reset state",
        64'({busy_o, done_o, tile_start_o, combo_idx_o}), 64'd0);
    rst_n = 1'b1;
    tick();

    // R8: stray tile_done while idle is ignored
    tile_done_i = 1'b1;
    tick();
    tick();
    tile_done_i = 1'b0;
    tick();
    chk(!tile_start_o && !busy_o && !done_o, "R8", "idle tile_done ignored",
        64'({tile_start_o, busy_o, done_o}), 64'd0);

    // R2 R6 R7: vector table
    for (int v = 0; v < 4; v++) begin
      prog(int'(VEC[v].ncombo), int'(VEC[v].base), v);
      run(int'(VEC[v].ncombo), int'(VEC[v].lat), int'(VEC[v].exp_tiles), 1'b0);
    end

    // R3: reserved key kind write is dropped
    prog(1, 2, 5);
    begin
      combo_cfg_t bad;
      bad = combo_cfg_t'(exp_cfg[0]);
      bad.key = KEY_RSVD;
      bad.tiles = 8'd1;
      bad.fmap = 8'hEE;
      wr(0, bad);
    end
    run(1, 1, 2, 1'b0);

    // R4 R5: write, start and last index while busy are ignored
    prog(3, 1, 3);
    run(3, 2, 6, 1'b1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule